// File: doc/BRIEF.md
# Widening Integer Sum Reducer

This block folds one vector operand into a single scalar that is twice as wide as the vector's elements. A start pulse captures the operation selector, the element width, the active length, the mask and the seed scalar. Elements then arrive one per cycle on a valid-qualified stream in index order. Each element that is enabled is widened to double width, either by zero fill or by sign fill, and added to an accumulator. The accumulator starts from the seed.

When the last element has been taken, the block presents the double-width sum together with a write strobe for element 0 of the destination. In the same cycle it presents a pulse that clears the restart index held by the surrounding pipeline. A configuration that is not legal, and a zero active length, both finish one cycle after the start pulse without any write. Legality of the register grouping is decided outside the block and arrives as a single bit.

Top module: `wred_sum_unit`

## Requirements
- R1: Selector value 6'b110000 picks the unsigned form: each element's low SEW bits are zero-extended to 2*SEW bits before the add.
- R2: Selector value 6'b110001 picks the signed form: each element's low SEW bits are sign-extended to 2*SEW bits before the add.
- R3: The accumulator starts from the low 2*SEW bits of `seed_i`, and the seed bits above 2*SEW have no effect on the result. The width code on `sew_i` is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit elements.
- R4: A legal start with `vl_i` = 0 gives `done_o` and `vstart_clr_o` high in the next cycle, with `result_we_o` and `illegal_o` low, and no element is consumed.
- R5: When `vm_i` is 0, element i contributes only if bit i of `mask_i` is 1. When `vm_i` is 1, every element from 0 to vl-1 contributes.
- R6: The sum wraps modulo 2^(2*SEW) without saturation, and `result_o` bits at and above 2*SEW are zero when `result_we_o` is high.
- R7: `done_o` is a one-cycle pulse in the cycle after the edge that takes element vl-1. On success it comes with `result_we_o` and `vstart_clr_o` high and `illegal_o` low.
- R8: A start with `cfg_legal_i` low, a selector other than the two widening sum codes, or width code 3 gives `done_o` and `illegal_o` high in the next cycle, with `result_we_o` and `vstart_clr_o` low.
- R9: Cycles with `elem_valid_i` low stall the reduction without changing it. Elements presented while the block is idle are ignored.
- R10: `busy_o` is high from the cycle after an accepted start with nonzero length until `done_o`. A start pulse while busy is ignored, and the configuration inputs are only sampled at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a reduction (taken only when idle) |
| funct6_i | input | 6 | Operation selector |
| vm_i | input | 1 | 1 = unmasked, 0 = use `mask_i` |
| vl_i | input | $clog2(MAX_VL+1) | Number of elements |
| sew_i | input | 2 | Element width code (0:8, 1:16, 2:32, 3:reserved) |
| cfg_legal_i | input | 1 | External legality of the widened grouping |
| mask_i | input | MAX_VL | Per-element enable bits, bit i for element i |
| seed_i | input | 2*MAX_SEW | Seed scalar (element 0 of the second operand) |
| elem_valid_i | input | 1 | Element stream valid |
| elem_data_i | input | MAX_SEW | Element value, low SEW bits used |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Completion was an illegal-instruction outcome |
| result_we_o | output | 1 | Write element 0 of the destination |
| vstart_clr_o | output | 1 | Clear the restart index |
| result_o | output | 2*MAX_SEW | Double-width sum |

## Verification
The bench feeds elements with the top bit set in each width, so a design that used the wrong fill would give a visibly different sum. It seeds with garbage above 2*SEW, which catches an accumulator that is not trimmed to width, and it forces a wrap at 2*SEW, which catches saturation or a missing carry trim. It also runs zero-length and each illegal cause, because a design that entered the run state there would hang or write a result. Gaps in the stream, a start pulse during a run, idle-time elements and configuration inputs changed right after start all target a design that samples live inputs rather than the values it latched. A full-length masked run at the largest width checks mask indexing at the far end of the vector.

// File: rtl/wred_pkg.sv
package wred_pkg;
    // Selector codes for the two widening sum forms; bit 0 marks the signed form.
    localparam logic [5:0] F6_WSUMU = 6'b110000;
    localparam logic [5:0] F6_WSUM  = 6'b110001;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } wred_st_e;
endpackage

// File: rtl/wred_decode.sv
module wred_decode
    import wred_pkg::*;
#(
    parameter int NUM_SEW = 3
) (
    input  logic [5:0] funct6_i,
    input  logic [1:0] sew_i,
    input  logic       cfg_legal_i,
    output logic       legal_o,
    output logic       signed_o
);
    logic op_ok;
    logic sew_ok;

    always_comb begin
        op_ok    = (funct6_i == F6_WSUMU) || (funct6_i == F6_WSUM);
        sew_ok   = (int'(sew_i) < NUM_SEW);
        legal_o  = cfg_legal_i && op_ok && sew_ok;
        signed_o = (funct6_i == F6_WSUM);
    end
endmodule

// File: rtl/wred_extend.sv
module wred_extend #(
    parameter int ELEM_W  = 32,
    parameter int ACC_W   = 64,
    parameter int NUM_SEW = 3
) (
    input  logic [ELEM_W-1:0] elem_i,
    input  logic [1:0]        sew_i,
    input  logic              sgn_i,
    output logic [ACC_W-1:0]  ext_o
);
    logic [NUM_SEW-1:0][ACC_W-1:0] cand;

    // One widened candidate per supported element width.
    for (genvar g = 0; g < NUM_SEW; g++) begin : g_width
        localparam int W = 8 << g;
        assign cand[g] = {{(ACC_W-W){sgn_i & elem_i[W-1]}}, elem_i[W-1:0]};
    end

    always_comb begin
        ext_o = '0;
        for (int k = 0; k < NUM_SEW; k++) begin
            if (int'(sew_i) == k) begin
                ext_o = cand[k];
            end
        end
    end
endmodule

// File: rtl/wred_sum_unit.sv
module wred_sum_unit
    import wred_pkg::*;
#(
    parameter int MAX_SEW = 32,
    parameter int MAX_VL  = 64,
    parameter int VL_W    = $clog2(MAX_VL + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [5:0]             funct6_i,
    input  logic                   vm_i,
    input  logic [VL_W-1:0]        vl_i,
    input  logic [1:0]             sew_i,
    input  logic                   cfg_legal_i,
    input  logic [MAX_VL-1:0]      mask_i,
    input  logic [2*MAX_SEW-1:0]   seed_i,
    input  logic                   elem_valid_i,
    input  logic [MAX_SEW-1:0]     elem_data_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   illegal_o,
    output logic                   result_we_o,
    output logic                   vstart_clr_o,
    output logic [2*MAX_SEW-1:0]   result_o
);
    localparam int ACC_W   = 2 * MAX_SEW;
    localparam int NUM_SEW = $clog2(MAX_SEW / 8) + 1;
    localparam int IDX_W   = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

    typedef struct packed {
        wred_st_e          st;
        logic [ACC_W-1:0]  acc;
        logic [VL_W-1:0]   idx;
        logic [VL_W-1:0]   vl;
        logic              vm;
        logic [1:0]        sew;
        logic [MAX_VL-1:0] mask;
        logic              sgn;
        logic              done;
        logic              ill;
        logic              wr;
    } wred_state_t;

    wred_state_t st_d, st_q;

    logic             dec_legal;
    logic             dec_signed;
    logic [ACC_W-1:0] elem_ext;
    logic             elem_on;

    // Keeps only the low 2*SEW bits of the accumulator.
    function automatic logic [ACC_W-1:0] width_mask(input logic [1:0] s);
        int w;
        w = 16 << int'(s);
        if (w >= ACC_W) begin
            return {ACC_W{1'b1}};
        end
        return {ACC_W{1'b1}} >> (ACC_W - w);
    endfunction

    wred_decode #(
        .NUM_SEW (NUM_SEW)
    ) u_decode (
        .funct6_i    (funct6_i),
        .sew_i       (sew_i),
        .cfg_legal_i (cfg_legal_i),
        .legal_o     (dec_legal),
        .signed_o    (dec_signed)
    );

    wred_extend #(
        .ELEM_W  (MAX_SEW),
        .ACC_W   (ACC_W),
        .NUM_SEW (NUM_SEW)
    ) u_extend (
        .elem_i (elem_data_i),
        .sew_i  (st_q.sew),
        .sgn_i  (st_q.sgn),
        .ext_o  (elem_ext)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.ill  = 1'b0;
        st_d.wr   = 1'b0;
        elem_on   = st_q.vm || st_q.mask[st_q.idx[IDX_W-1:0]];

        unique case (st_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (!dec_legal) begin
                        st_d.done = 1'b1;
                        st_d.ill  = 1'b1;
                    end else if (vl_i == '0) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.st   = ST_RUN;
                        st_d.acc  = seed_i & width_mask(sew_i);
                        st_d.idx  = '0;
                        st_d.vl   = vl_i;
                        st_d.vm   = vm_i;
                        st_d.sew  = sew_i;
                        st_d.mask = mask_i;
                        st_d.sgn  = dec_signed;
                    end
                end
            end
            ST_RUN: begin
                if (elem_valid_i) begin
                    if (elem_on) begin
                        st_d.acc = (st_q.acc + elem_ext) & width_mask(st_q.sew);
                    end
                    st_d.idx = st_q.idx + 1'b1;
                    if (st_q.idx == st_q.vl - 1'b1) begin
                        st_d.st   = ST_IDLE;
                        st_d.done = 1'b1;
                        st_d.wr   = 1'b1;
                    end
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o       = (st_q.st == ST_RUN);
    assign done_o       = st_q.done;
    assign illegal_o    = st_q.ill;
    assign result_we_o  = st_q.wr;
    assign vstart_clr_o = st_q.done & ~st_q.ill;
    assign result_o     = st_q.acc;
endmodule

// File: rtl/wred_sum_unit_chk.sv
module wred_sum_unit_chk #(
    parameter int MAX_SEW = 32,
    parameter int MAX_VL  = 64,
    parameter int VL_W    = $clog2(MAX_VL + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic [VL_W-1:0]      vl_i,
    input logic [1:0]           sew_i,
    input logic                 cfg_legal_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic                 illegal_o,
    input logic                 result_we_o,
    input logic                 vstart_clr_o,
    input logic [2*MAX_SEW-1:0] result_o
);
    logic [1:0] sew_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sew_cap <= '0;
        end else if (start_i && !busy_o) begin
            sew_cap <= sew_i;
        end
    end

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        result_we_o |-> (done_o && vstart_clr_o && !illegal_o));

    a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (done_o && !result_we_o && !vstart_clr_o));

    a_r8_illegal_next: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !cfg_legal_i) |=> (done_o && illegal_o));

    a_r4_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && vl_i == '0) |=> (done_o && !result_we_o && !busy_o));

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        result_we_o |-> ((result_o >> (16 << int'(sew_cap))) == '0));

    a_r10_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

bind wred_sum_unit wred_sum_unit_chk #(
    .MAX_SEW (MAX_SEW),
    .MAX_VL  (MAX_VL),
    .VL_W    (VL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .vl_i         (vl_i),
    .sew_i        (sew_i),
    .cfg_legal_i  (cfg_legal_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .illegal_o    (illegal_o),
    .result_we_o  (result_we_o),
    .vstart_clr_o (vstart_clr_o),
    .result_o     (result_o)
);

// File: tb/tb_wred_sum_unit.sv
module tb_wred_sum_unit;
    localparam int MAX_SEW = 32;
    localparam int MAX_VL  = 64;
    localparam int VL_W    = $clog2(MAX_VL + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic [5:0]           funct6_i = '0;
    logic                 vm_i = 1'b0;
    logic [VL_W-1:0]      vl_i = '0;
    logic [1:0]           sew_i = '0;
    logic                 cfg_legal_i = 1'b0;
    logic [MAX_VL-1:0]    mask_i = '0;
    logic [2*MAX_SEW-1:0] seed_i = '0;
    logic                 elem_valid_i = 1'b0;
    logic [MAX_SEW-1:0]   elem_data_i = '0;
    logic                 busy_o, done_o, illegal_o, result_we_o, vstart_clr_o;
    logic [2*MAX_SEW-1:0] result_o;

    logic [31:0] elem_mem [0:MAX_VL-1];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    wred_sum_unit #(.MAX_SEW(MAX_SEW), .MAX_VL(MAX_VL)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .funct6_i(funct6_i),
        .vm_i(vm_i), .vl_i(vl_i), .sew_i(sew_i), .cfg_legal_i(cfg_legal_i),
        .mask_i(mask_i), .seed_i(seed_i), .elem_valid_i(elem_valid_i),
        .elem_data_i(elem_data_i), .busy_o(busy_o), .done_o(done_o),
        .illegal_o(illegal_o), .result_we_o(result_we_o),
        .vstart_clr_o(vstart_clr_o), .result_o(result_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [5:0] f6, input logic vm, input int vl,
                                          input logic [1:0] sew, input logic [63:0] mask,
                                          input logic [63:0] seed);
        int w, ew;
        logic [63:0] m, em, acc, e;
        w   = 16 << sew;
        ew  = w / 2;
        m   = (w == 64) ? '1 : ((64'd1 << w) - 1);
        em  = (64'd1 << ew) - 1;
        acc = seed & m;
        for (int i = 0; i < vl; i++) begin
            if (vm || mask[i]) begin
                e = {32'd0, elem_mem[i]} & em;
                if (f6[0] && e[ew-1]) e = e | ~em;
                acc = (acc + e) & m;
            end
        end
        return acc;
    endfunction

    task automatic run_op(input string req, input logic [5:0] f6, input logic vm, input int vl,
                          input logic [1:0] sew, input logic legal, input logic [63:0] mask,
                          input logic [63:0] seed, input bit gap, input bit poke);
        bit ill;
        logic [63:0] exp;
        ill = !legal || (f6 != 6'b110000 && f6 != 6'b110001) || sew == 2'd3;
        exp = ill ? 64'd0 : model(f6, vm, vl, sew, mask, seed);
        @(negedge clk);
        start_i = 1'b1; funct6_i = f6; vm_i = vm; vl_i = VL_W'(vl);
        sew_i = sew; cfg_legal_i = legal; mask_i = mask; seed_i = seed;
        @(negedge clk);
        // Scramble configuration to show it was latched at start (R10).
        start_i = 1'b0; funct6_i = 6'b000000; vm_i = ~vm; vl_i = '0;
        sew_i = 2'd3; cfg_legal_i = 1'b0; mask_i = ~mask; seed_i = ~seed;
        if (ill || vl == 0) begin
            chk({req, " done after start"}, 64'(done_o), 64'd1);
            chk({req, " illegal flag"}, 64'(illegal_o), 64'(ill));
            chk({req, " no write"}, 64'(result_we_o), 64'd0);
            chk({req, " vstart clear"}, 64'(vstart_clr_o), 64'(!ill));
            chk({req, " not busy"}, 64'(busy_o), 64'd0);
            @(negedge clk);
            chk({req, " done pulse ends"}, 64'(done_o), 64'd0);
            return;
        end
        chk({req, " R10 busy after start"}, 64'(busy_o), 64'd1);
        for (int i = 0; i < vl; i++) begin
            if (gap && (i % 3 == 1)) begin
                elem_valid_i = 1'b0;
                elem_data_i  = 32'hFFFF_FFFF;
                @(negedge clk);
                chk({req, " R9 stall no done"}, 64'(done_o), 64'd0);
            end
            if (poke && i == 1) begin
                start_i = 1'b1; funct6_i = 6'b110001; vl_i = VL_W'(1); cfg_legal_i = 1'b1;
            end
            elem_valid_i = 1'b1;
            elem_data_i  = elem_mem[i];
            @(negedge clk);
            start_i = 1'b0;
            if (i < vl - 1) chk({req, " R7 no early done"}, 64'(done_o), 64'd0);
        end
        elem_valid_i = 1'b0;
        chk({req, " R7 done"}, 64'(done_o), 64'd1);
        chk({req, " R7 write"}, 64'(result_we_o), 64'd1);
        chk({req, " R7 vstart clear"}, 64'(vstart_clr_o), 64'd1);
        chk({req, " R7 not illegal"}, 64'(illegal_o), 64'd0);
        chk({req, " result"}, result_o, exp);
        chk({req, " R10 idle at done"}, 64'(busy_o), 64'd0);
        @(negedge clk);
        chk({req, " R7 done pulse ends"}, 64'(done_o), 64'd0);
    endtask

    task automatic idle_noise();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            elem_valid_i = 1'b1;
            elem_data_i  = 32'h7777_0000 + 32'(i);
        end
        @(negedge clk);
        elem_valid_i = 1'b0;
        chk("R9 idle elements no done", 64'(done_o), 64'd0);
        chk("R9 idle elements no busy", 64'(busy_o), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < MAX_VL; i++) begin
            elem_mem[i] = (32'h9E37_79B9 * 32'(i + 1)) ^ 32'(i << 3);
        end
        repeat (3) @(negedge clk);
        chk("reset done", 64'(done_o), 64'd0);
        chk("reset busy", 64'(busy_o), 64'd0);
        chk("reset illegal", 64'(illegal_o), 64'd0);
        chk("reset write", 64'(result_we_o), 64'd0);
        rst_n = 1'b1;

        // R1 / R2: top-bit-set bytes under both fills.
        elem_mem[0] = 32'h0000_00FF; elem_mem[1] = 32'h0000_0080;
        elem_mem[2] = 32'h0000_0001; elem_mem[3] = 32'h0000_007F;
        run_op("R1 unsigned sew8", 6'b110000, 1'b1, 4, 2'd0, 1'b1, '0, 64'h10, 0, 0);
        chk("R1 expected constant", result_o, 64'h020F);
        run_op("R2 signed sew8", 6'b110001, 1'b1, 4, 2'd0, 1'b1, '0, 64'h10, 0, 0);
        chk("R2 expected constant", result_o, 64'h000F);

        // R3: seed bits above 2*SEW ignored.
        run_op("R3 seed trim", 6'b110000, 1'b1, 4, 2'd0, 1'b1, '0, 64'hDEAD_BEEF_CAFE_1234, 0, 0);
        chk("R3 expected constant", result_o, 64'h1433);

        // R4: zero length.
        run_op("R4 vl zero", 6'b110001, 1'b1, 0, 2'd1, 1'b1, '1, 64'h55, 0, 0);

        // R5: masked, alternating bits, then vm=1 with empty mask.
        for (int i = 0; i < MAX_VL; i++) elem_mem[i] = (32'h9E37_79B9 * 32'(i + 1)) ^ 32'(i << 3);
        run_op("R5 masked sew16", 6'b110000, 1'b0, 9, 2'd1, 1'b1, 64'h0000_0000_0000_0155, 64'h3, 0, 0);
        run_op("R5 vm ignores mask", 6'b110001, 1'b1, 9, 2'd1, 1'b1, 64'd0, 64'h3, 0, 0);

        // R6: wrap at 2*SEW for sew16.
        elem_mem[0] = 32'h0000_0001;
        run_op("R6 wrap sew16", 6'b110000, 1'b1, 1, 2'd1, 1'b1, '0, 64'hFFFF_FFFF, 0, 0);
        chk("R6 wrap to zero", result_o, 64'd0);

        // R9: stalls plus idle-time elements; R2 with sew32 negatives.
        for (int i = 0; i < MAX_VL; i++) elem_mem[i] = (32'h9E37_79B9 * 32'(i + 1)) ^ 32'(i << 3);
        idle_noise();
        run_op("R9 stalls sew32", 6'b110001, 1'b1, 10, 2'd2, 1'b1, '0, 64'h8000_0000_0000_0000, 1, 0);

        // R10: start while busy ignored.
        run_op("R10 start while busy", 6'b110000, 1'b1, 6, 2'd0, 1'b1, '0, 64'h7, 0, 1);

        // R8: each illegal cause.
        run_op("R8 cfg illegal", 6'b110000, 1'b1, 4, 2'd0, 1'b0, '0, 64'h1, 0, 0);
        run_op("R8 bad selector", 6'b000000, 1'b1, 4, 2'd0, 1'b1, '0, 64'h1, 0, 0);
        run_op("R8 reserved width", 6'b110001, 1'b1, 4, 2'd3, 1'b1, '0, 64'h1, 0, 0);

        // R5 full length: far-end mask bits at the widest width.
        run_op("R5 full length sew32", 6'b110000, 1'b0, MAX_VL, 2'd2, 1'b1,
               64'hC000_0000_0000_0003, 64'h1, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule